// File: doc/BRIEF.md
# Pipelined Two-Input Alpha Blender

This block mixes two 12-bit pixel streams into one 13-bit result using a 12-bit weight. Every clock it takes one pixel from each stream and forms `alpha*A + (1 - alpha)*B`. The weight is an unsigned fixed-point number with one integer bit, and it is held in a register that loads only while the load enable is high. Weights above unity are pulled back to exactly unity when they are captured.

The number format (signed or unsigned) and the rounding precision are sampled on the same edge as their pixel pair. They then travel down the pipeline with that pair, so either one may change on any cycle without disturbing results already in flight. The pipeline has three register stages: capture, multiply-accumulate, and round/output. The output carries one fractional bit. It can be rounded to 8, 10, 12 or 13 significant bits, and it saturates instead of wrapping when rounding carries past full scale. A separate enable flag stands in for a high-impedance output driver.

Top module: `pix_alpha_blend`

## Requirements
- R1: The result for the inputs sampled at rising edge k appears on `dout` just after rising edge k+2 (three register stages).
- R2: `dina` is weighted by alpha and `dinb` by (1 - alpha), and the two products are summed. Alpha bit 11 has weight 1 and bit 0 has weight 2^-11.
- R3: `dout[12:1]` holds the integer part of the mix and `dout[0]` holds the half bit. The value is two's complement when the sample was signed.
- R4: A captured alpha above 12'h800 is replaced by 12'h800, which is exactly unity.
- R5: When `mixen` is high, alpha is loaded on the clock edge. When `mixen` is low, the previously loaded alpha is used.
- R6: With `tc` low, both pixels of that sample are two's complement. With `tc` high, they are unsigned. The setting applies only to the pair sampled on the same edge.
- R7: `rnd` selects how many most-significant bits of `dout` are kept: 2'b00 keeps 8, 2'b01 keeps 10, 2'b10 keeps 12 and 2'b11 keeps all 13. The code applies only to the pair sampled on the same edge.
- R8: Rounding adds one half of the kept LSB to the full-precision sum, then clears every discarded bit. Ties therefore move toward +infinity.
- R9: If rounding would exceed the format's largest value, `dout` is set to that largest value with the discarded bits cleared. The largest value is 13'h1FFF for unsigned samples and 13'h0FFF for signed samples.
- R10: `dout_en` is high only while `oe` is low and at least three edges have passed since reset was released.
- R11: A synchronous active-high `rst` clears `dout`, `dout_en` and the held alpha to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dina | input | 12 | Pixel stream A, weighted by alpha |
| dinb | input | 12 | Pixel stream B, weighted by one minus alpha |
| alpha | input | 12 | Mix weight, unsigned with 11 fraction bits |
| mixen | input | 1 | Loads alpha when high, holds it when low |
| tc | input | 1 | Sample format: 0 two's complement, 1 unsigned |
| rnd | input | 2 | Output precision code for this sample |
| oe | input | 1 | Output enable, active low |
| dout | output | 13 | Rounded mix, one fractional bit |
| dout_en | output | 1 | High when the output is driven |

## Verification
The hardest case to reach is a change of format or rounding code on every cycle while older samples are still in the pipeline. A slip of one stage between a sample and its controls would only show up when neighbouring samples use different settings. The stimulus therefore sends runs of the same pixel pair through back to back with `tc` or `rnd` alternating, so each output differs from its neighbours only because of the control sampled with it. Saturation needs full-scale inputs at unity weight combined with coarse rounding, and these vectors are placed in the table explicitly.

// File: rtl/blend_pkg.sv
package blend_pkg;

  typedef enum logic [1:0] {
    RND_8    = 2'b00,
    RND_10   = 2'b01,
    RND_12   = 2'b10,
    RND_FULL = 2'b11
  } rnd_t;

  // Number of low output bits cleared for a given precision code.
  function automatic int drop_bits(input rnd_t code, input int out_w);
    case (code)
      RND_8:   return out_w - 8;
      RND_10:  return out_w - 10;
      RND_12:  return out_w - 12;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/blend_capture.sv
module blend_capture
  import blend_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int AL_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PIX_W-1:0]        dina,
  input  logic [PIX_W-1:0]        dinb,
  input  logic [AL_W-1:0]         alpha,
  input  logic                    mixen,
  input  logic                    tc,
  input  rnd_t                    rnd,
  output logic signed [PIX_W:0]   a_o,
  output logic signed [PIX_W:0]   b_o,
  output logic [AL_W-1:0]         alpha_o,
  output logic                    tc_o,
  output rnd_t                    rnd_o,
  output logic                    vld_o
);

  localparam logic [AL_W-1:0] UNITY = AL_W'(1) << (AL_W - 1);

  logic [AL_W-1:0] alpha_sat;
  assign alpha_sat = (alpha > UNITY) ? UNITY : alpha;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_o     <= '0;
      b_o     <= '0;
      alpha_o <= '0;
      tc_o    <= 1'b0;
      rnd_o   <= RND_FULL;
      vld_o   <= 1'b0;
    end else begin
      // Extend by one bit according to the format sampled with this pair.
      a_o   <= {(tc ? 1'b0 : dina[PIX_W-1]), dina};
      b_o   <= {(tc ? 1'b0 : dinb[PIX_W-1]), dinb};
      tc_o  <= tc;
      rnd_o <= rnd;
      vld_o <= 1'b1;
      if (mixen) alpha_o <= alpha_sat;
    end
  end

  p_alpha_le_unity_r4: assert property (@(posedge clk) disable iff (rst)
    alpha_o <= UNITY);

  p_alpha_held_r5: assert property (@(posedge clk) disable iff (rst)
    !mixen |=> $stable(alpha_o));

endmodule

// File: rtl/blend_mac.sv
module blend_mac
  import blend_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int AL_W     = 12,
  parameter bit ONE_MULT = 1'b1,
  localparam int SUM_W   = PIX_W + AL_W + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [PIX_W:0]   a_i,
  input  logic signed [PIX_W:0]   b_i,
  input  logic [AL_W-1:0]         alpha_i,
  input  logic                    tc_i,
  input  rnd_t                    rnd_i,
  input  logic                    vld_i,
  output logic signed [SUM_W-1:0] sum_o,
  output logic                    tc_o,
  output rnd_t                    rnd_o,
  output logic                    vld_o
);

  localparam logic [AL_W:0] UNITY_X = (AL_W+1)'(1) << (AL_W - 1);

  logic signed [SUM_W-1:0] sum_d;
  logic signed [AL_W:0]    coef_a;

  assign coef_a = $signed({1'b0, alpha_i});

  generate
    if (ONE_MULT) begin : g_one_mult
      // B*unity + alpha*(A - B): one multiplier, one shift.
      logic signed [PIX_W+1:0] diff;
      assign diff  = (PIX_W+2)'(a_i) - (PIX_W+2)'(b_i);
      assign sum_d = (SUM_W'(b_i) <<< (AL_W - 1)) + SUM_W'(diff) * SUM_W'(coef_a);
    end else begin : g_two_mult
      logic signed [AL_W:0] coef_b;
      assign coef_b = $signed(UNITY_X - {1'b0, alpha_i});
      assign sum_d  = SUM_W'(a_i) * SUM_W'(coef_a) + SUM_W'(b_i) * SUM_W'(coef_b);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o <= '0;
      tc_o  <= 1'b0;
      rnd_o <= RND_FULL;
      vld_o <= 1'b0;
    end else begin
      sum_o <= sum_d;
      tc_o  <= tc_i;
      rnd_o <= rnd_i;
      vld_o <= vld_i;
    end
  end

endmodule

// File: rtl/blend_round.sv
module blend_round
  import blend_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int AL_W   = 12,
  parameter int OUT_W  = PIX_W + 1,
  localparam int SUM_W = PIX_W + AL_W + 3,
  localparam int RW    = SUM_W + 1,
  localparam int SH    = AL_W - 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic                    tc_i,
  input  rnd_t                    rnd_i,
  input  logic                    vld_i,
  output logic [OUT_W-1:0]        dout_o,
  output logic                    vld_o
);

  localparam logic [OUT_W-1:0] LOW8 = (OUT_W'(1) << (OUT_W - 8)) - OUT_W'(1);

  int                   drop;
  logic signed [RW-1:0] rsum, keep_mask, qv, lim;

  always_comb begin
    drop      = drop_bits(rnd_i, OUT_W);
    rsum      = RW'(sum_i) + (RW'(1) << (SH + drop - 1));
    keep_mask = ~((RW'(1) << drop) - RW'(1));
    qv        = (rsum >>> SH) & keep_mask;
    lim       = (tc_i ? ((RW'(1) << OUT_W) - RW'(1))
                      : ((RW'(1) << (OUT_W - 1)) - RW'(1))) & keep_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      dout_o <= OUT_W'((qv > lim) ? lim : qv);
      vld_o  <= vld_i;
    end
  end

  p_round8_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (vld_i && rnd_i == RND_8) |=> ((dout_o & LOW8) == '0));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !tc_i && !sum_i[SUM_W-1]) |=> !dout_o[OUT_W-1]);

endmodule

// File: rtl/pix_alpha_blend.sv
module pix_alpha_blend
  import blend_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int AL_W     = 12,
  parameter bit ONE_MULT = 1'b1,
  localparam int OUT_W   = PIX_W + 1,
  localparam int SUM_W   = PIX_W + AL_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] dina,
  input  logic [PIX_W-1:0] dinb,
  input  logic [AL_W-1:0]  alpha,
  input  logic             mixen,
  input  logic             tc,
  input  logic [1:0]       rnd,
  input  logic             oe,
  output logic [OUT_W-1:0] dout,
  output logic             dout_en
);

  logic signed [PIX_W:0]   s1_a, s1_b;
  logic [AL_W-1:0]         s1_alpha;
  logic                    s1_tc, s1_vld;
  rnd_t                    s1_rnd;
  logic signed [SUM_W-1:0] s2_sum;
  logic                    s2_tc, s2_vld;
  rnd_t                    s2_rnd;
  logic                    s3_vld;

  blend_capture #(.PIX_W(PIX_W), .AL_W(AL_W)) u_cap (
    .clk(clk), .rst(rst), .dina(dina), .dinb(dinb), .alpha(alpha),
    .mixen(mixen), .tc(tc), .rnd(rnd_t'(rnd)),
    .a_o(s1_a), .b_o(s1_b), .alpha_o(s1_alpha), .tc_o(s1_tc),
    .rnd_o(s1_rnd), .vld_o(s1_vld)
  );

  blend_mac #(.PIX_W(PIX_W), .AL_W(AL_W), .ONE_MULT(ONE_MULT)) u_mac (
    .clk(clk), .rst(rst), .a_i(s1_a), .b_i(s1_b), .alpha_i(s1_alpha),
    .tc_i(s1_tc), .rnd_i(s1_rnd), .vld_i(s1_vld),
    .sum_o(s2_sum), .tc_o(s2_tc), .rnd_o(s2_rnd), .vld_o(s2_vld)
  );

  blend_round #(.PIX_W(PIX_W), .AL_W(AL_W), .OUT_W(OUT_W)) u_rnd (
    .clk(clk), .rst(rst), .sum_i(s2_sum), .tc_i(s2_tc), .rnd_i(s2_rnd),
    .vld_i(s2_vld), .dout_o(dout), .vld_o(s3_vld)
  );

  assign dout_en = s3_vld & ~oe;

  p_enable_after_fill_r10: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> !$past(rst));

endmodule

// File: tb/tb_pix_alpha_blend.sv
module tb_pix_alpha_blend;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] dina = '0, dinb = '0, alpha = '0;
  logic        mixen = 1'b0, tc = 1'b1, oe = 1'b0;
  logic [1:0]  rnd = 2'b11;
  logic [12:0] dout;
  logic        dout_en;

  int n_chk = 0, n_fail = 0, m_alpha = 0;
  logic [39:0] seq [0:15];
  int seq_n = 0;

  always #5 clk = ~clk;

  pix_alpha_blend dut (
    .clk(clk), .rst(rst), .dina(dina), .dinb(dinb), .alpha(alpha),
    .mixen(mixen), .tc(tc), .rnd(rnd), .oe(oe), .dout(dout), .dout_en(dout_en)
  );

  // Vector layout: {tc, rnd[1:0], mixen, alpha[11:0], dina[11:0], dinb[11:0]}
  localparam logic [39:0] TBL [16] = '{
    40'hF800123456, 40'hF000123456, 40'hF400FFF000, 40'hF400001002,
    40'hFC00ABC111, 40'h1555800F7F, 40'h32AAF00100, 40'h57FF7FF800,
    40'h7001FFF001, 40'h8FFF200300, 40'hAFFF0F0F0F, 40'hCFFFABCDEF,
    40'hFFFFFFFFFF, 40'h9800FFFFFE, 40'h18007FF000, 40'hF3FF8007FF
  };

  function automatic logic [12:0] model(input bit tcv, input logic [1:0] r,
                                        input int al, input logic [11:0] a,
                                        input logic [11:0] b);
    int av, bv, s, n, sh, d, mx;
    av = int'(a); bv = int'(b);
    if (!tcv && a[11]) av = av - 4096;
    if (!tcv && b[11]) bv = bv - 4096;
    s  = av * al + bv * (2048 - al);
    n  = (r == 2'b00) ? 8 : (r == 2'b01) ? 10 : (r == 2'b10) ? 12 : 13;
    sh = 10 + 13 - n;
    d  = ((s + (1 << (sh - 1))) >>> sh) * (1 << (13 - n));
    mx = tcv ? 8191 : 4095;
    mx = (mx >> (13 - n)) << (13 - n);
    if (d > mx) d = mx;
    return 13'(d);
  endfunction

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_seq(input string tag);
    logic [12:0] expv [0:15];
    for (int j = 0; j < seq_n + 3; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        check(tag, dout, expv[j-3]);
        check({tag, " enable"}, {12'b0, dout_en}, 13'd1);
      end
      if (j < seq_n) begin
        {tc, rnd, mixen, alpha, dina, dinb} = seq[j];
        if (mixen) m_alpha = (alpha > 12'h800) ? 2048 : int'(alpha);
        expv[j] = model(tc, rnd, m_alpha, dina, dinb);
      end else begin
        mixen = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset dout", dout, 13'd0);
    check("R11 reset enable", {12'b0, dout_en}, 13'd0);
    rst = 1'b0;

    // R11: alpha cleared by reset, so output equals B
    seq[0] = 40'hE000100300; seq_n = 1; m_alpha = 0;
    run_seq("R11 alpha zero after reset");

    for (int i = 0; i < 16; i++) seq[i] = TBL[i];
    seq_n = 16;
    run_seq("R1 R2 R3 R4 R6 R7 R9 table");

    seq[0] = 40'hF200400000; seq[1] = 40'hE7FF400000; seq[2] = 40'hE7FF123456;
    seq_n = 3;
    run_seq("R5 alpha hold");

    seq[0] = 40'hFFFF010FFF; seq_n = 1;
    run_seq("R4 clamp to unity");

    seq[0] = 40'h7400FFF000; seq[1] = 40'hF400FFF000; seq[2] = 40'h7400FFF000;
    seq_n = 3;
    run_seq("R6 per-sample format");

    seq[0] = 40'hF001FFF000; seq[1] = 40'hD001FFF000; seq[2] = 40'hB001FFF000;
    seq[3] = 40'h9001FFF000; seq[4] = 40'hF400001002; seq[5] = 40'hD400001002;
    seq[6] = 40'h5400FFFFFE;
    seq_n = 7;
    run_seq("R7 R8 rounding per sample");

    // R10: enable follows oe
    @(negedge clk); oe = 1'b1; #1;
    check("R10 oe high disables", {12'b0, dout_en}, 13'd0);
    oe = 1'b0; #1;
    check("R10 oe low enables", {12'b0, dout_en}, 13'd1);

    // R11/R10: reset mid-run, then fill latency
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset clears dout", dout, 13'd0);
    check("R11 reset clears enable", {12'b0, dout_en}, 13'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 not filled after 1 edge", {12'b0, dout_en}, 13'd0);
    @(negedge clk);
    check("R10 not filled after 2 edges", {12'b0, dout_en}, 13'd0);
    @(negedge clk);
    check("R10 filled after 3 edges", {12'b0, dout_en}, 13'd1);

    report();
  end

endmodule